// File: doc/BRIEF.md
# PTP Receive Snapshot Filter

This block sits behind a receive frame parser and decides, for each frame, whether the timestamp of that frame should be captured. The parser hands over a one-cycle frame strobe together with the frame's transport class (not PTP, PTP directly over Ethernet, PTP in UDP over IPv4, PTP in UDP over IPv6), the version number from the PTP header, the 4-bit message code and a flag that says whether the destination address matched one of the station's addresses.

The decision depends on a global enable pin and on a 10-bit configuration word. The configuration word is held in a register inside the block and is loaded through a write strobe. Its fields select snapshot-all, the per-transport enables, version-2 interpretation, event-only mode, master role, destination-address filtering and a 2-bit selection of message groups. The result is one registered pulse that appears in the cycle after the frame strobe.

Top module: `ptp_rx_snap_filter`

## Requirements
- R1: After reset `snap_take_o` is low. The configuration word resets to 10'h002, so only UDP over IPv4 is enabled, with version-1 interpretation, slave role, event-only off and selection 0. With `ts_en_i` high and this configuration, a version-1 SYNC (version 1, code 0) over IPv4 is captured, while the same frame over IPv6 or directly over Ethernet is not.
- R2: While `ts_en_i` is low, no frame is captured, whatever the configuration holds.
- R3: A frame strobed in cycle N gives `snap_take_o` high in cycle N+1 only, so each frame produces exactly one pulse. Frames strobed back to back give back-to-back pulses.
- R4: With snapshot-all (config bit 0) set and `ts_en_i` high, every strobed frame is captured. This includes non-PTP frames (transport 0), frames on disabled transports and excluded message types.
- R5: The transport code is 0 for not PTP, 1 for Ethernet, 2 for UDP/IPv4 and 3 for UDP/IPv6. The enables are config bit 1 (IPv4), bit 2 (IPv6) and bit 3 (Ethernet). A frame on a transport whose enable is clear is not captured. Without snapshot-all, a non-PTP frame is never captured.
- R6: Config bit 4 selects the version-2 interpretation, which requires header version 2. When bit 4 is clear, the version-1 interpretation applies and requires header version 1. A frame whose version does not match is not captured. Version-1 codes are: SYNC 0, Delay_Req 1, Follow_Up 2, Delay_Resp 3, Management 4.
- R7: Version-2 codes are: SYNC 0, Delay_Req 1, Pdelay_Req 2, Pdelay_Resp 3, Follow_Up 8, Delay_Resp 9, Pdelay_Resp_Follow_Up 10, Announce 11, Signaling 12, Management 13. With event-only (bit 5) set, selection 0 and the slave role (bit 6 clear), only SYNC and Pdelay_Req are captured.
- R8: With selection 0 and the master role (bit 6 set), only Delay_Req and Pdelay_Resp are captured among the event messages.
- R9: With event-only clear, the general messages Follow_Up, Delay_Resp and Pdelay_Resp_Follow_Up are captured in addition to the role's event messages. Announce, Signaling and Management are never captured, and the event set stays role-filtered.
- R10: Selection 1 (bits 9:8) captures all four event messages, whatever the role.
- R11: Selection 2 captures only the peer-delay events Pdelay_Req and Pdelay_Resp. Selection 3 captures the peer-delay events together with SYNC (slave role) or Delay_Req (master role).
- R12: With address filtering (bit 7) set, an Ethernet-transported PTP frame is captured only if `frm_da_match_i` is high. UDP-transported frames are not affected by this filter.
- R13: Message codes that are not defined for the selected version are never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_en_i | input | 1 | Global timestamp enable |
| cfg_wr_i | input | 1 | Load strobe for the configuration word |
| cfg_data_i | input | 10 | Configuration word written when `cfg_wr_i` is high |
| frm_valid_i | input | 1 | One-cycle strobe marking a parsed frame |
| frm_transport_i | input | 2 | Transport class of the frame |
| frm_ver_i | input | 4 | PTP header version |
| frm_msg_i | input | 4 | PTP message code |
| frm_da_match_i | input | 1 | Destination address matched a station address |
| snap_take_o | output | 1 | Capture decision, a one-cycle pulse |

## Verification
The bench goes after several corner cases.

- **Reset value of the configuration word.** Only an IPv4 frame is captured straight after reset. A design that resets every enable to zero would miss that frame, and one that resets all enables to one would wrongly capture the IPv6 and Ethernet frames.
- **Version mismatch in both directions.** A design that keyed only on message codes would capture a version-1 SYNC under version-2 interpretation.
- **Role filtering.** This is checked in each of the four selection values, where a swapped role or selection would capture the wrong half of the event set.
- **Address filtering.** A filter applied to every transport would drop a UDP frame without an address match.
- **Snapshot-all precedence.** A filter applied ahead of snapshot-all would drop a non-PTP or Announce frame.
- **Pulse shape.** A latched decision would show as a second high cycle.

// File: rtl/ptp_filt_pkg.sv
package ptp_filt_pkg;

  localparam int unsigned VER_W = 4;
  localparam int unsigned MSG_W = 4;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [1:0] {
    TR_NONE = 2'd0,
    TR_ETH  = 2'd1,
    TR_UDP4 = 2'd2,
    TR_UDP6 = 2'd3
  } transport_e;

  // Packed MSB first: bits 9:8 sel, 7 da_filt, 6 master, 5 event_only,
  // 4 v2_sel, 3 eth_en, 2 ipv6_en, 1 ipv4_en, 0 snap_all
  typedef struct packed {
    logic [SEL_W-1:0] snap_sel;
    logic             da_filt;
    logic             master;
    logic             event_only;
    logic             v2_sel;
    logic             eth_en;
    logic             ipv6_en;
    logic             ipv4_en;
    logic             snap_all;
  } snap_cfg_t;

  localparam int unsigned CFG_W = $bits(snap_cfg_t);
  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(10'h002);

  typedef struct packed {
    logic known;
    logic excluded;
    logic general;
    logic sync;
    logic dreq;
    logic preq;
    logic presp;
  } msg_cls_t;

endpackage

// File: rtl/ptp_cfg_reg.sv
module ptp_cfg_reg
  import ptp_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output snap_cfg_t        cfg_o
);

  logic [CFG_W-1:0] cfg_d;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) cfg_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = snap_cfg_t'(cfg_q);

endmodule

// File: rtl/ptp_msg_classify.sv
module ptp_msg_classify
  import ptp_filt_pkg::*;
(
  input  logic             v2_sel_i,
  input  logic [VER_W-1:0] ver_i,
  input  logic [MSG_W-1:0] msg_i,
  output msg_cls_t         cls_o
);

  localparam logic [VER_W-1:0] VER_ONE = VER_W'(1);
  localparam logic [VER_W-1:0] VER_TWO = VER_W'(2);

  logic ver_ok;

  always_comb begin
    ver_ok = v2_sel_i ? (ver_i == VER_TWO) : (ver_i == VER_ONE);
    cls_o  = '0;
    if (ver_ok) begin
      if (v2_sel_i) begin
        case (msg_i)
          MSG_W'(0):  begin cls_o.known = 1'b1; cls_o.sync  = 1'b1; end
          MSG_W'(1):  begin cls_o.known = 1'b1; cls_o.dreq  = 1'b1; end
          MSG_W'(2):  begin cls_o.known = 1'b1; cls_o.preq  = 1'b1; end
          MSG_W'(3):  begin cls_o.known = 1'b1; cls_o.presp = 1'b1; end
          MSG_W'(8), MSG_W'(9), MSG_W'(10):
                      begin cls_o.known = 1'b1; cls_o.general = 1'b1; end
          MSG_W'(11), MSG_W'(12), MSG_W'(13):
                      begin cls_o.known = 1'b1; cls_o.excluded = 1'b1; end
          default:    cls_o = '0;
        endcase
      end else begin
        case (msg_i)
          MSG_W'(0):  begin cls_o.known = 1'b1; cls_o.sync  = 1'b1; end
          MSG_W'(1):  begin cls_o.known = 1'b1; cls_o.dreq  = 1'b1; end
          MSG_W'(2), MSG_W'(3):
                      begin cls_o.known = 1'b1; cls_o.general = 1'b1; end
          MSG_W'(4):  begin cls_o.known = 1'b1; cls_o.excluded = 1'b1; end
          default:    cls_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ptp_transport_gate.sv
module ptp_transport_gate
  import ptp_filt_pkg::*;
(
  input  logic       ipv4_en_i,
  input  logic       ipv6_en_i,
  input  logic       eth_en_i,
  input  logic       da_filt_i,
  input  transport_e transport_i,
  input  logic       da_match_i,
  output logic       pass_o
);

  always_comb begin
    unique case (transport_i)
      TR_ETH:  pass_o = eth_en_i && (!da_filt_i || da_match_i);
      TR_UDP4: pass_o = ipv4_en_i;
      TR_UDP6: pass_o = ipv6_en_i;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ptp_snap_policy.sv
module ptp_snap_policy
  import ptp_filt_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             event_only_i,
  input  logic             master_i,
  input  msg_cls_t         cls_i,
  output logic             want_o
);

  logic own_ev;
  logic peer_ev;
  logic ev_hit;

  always_comb begin
    own_ev  = master_i ? cls_i.dreq : cls_i.sync;
    peer_ev = cls_i.preq || cls_i.presp;
    unique case (sel_i)
      SEL_W'(0): ev_hit = master_i ? (cls_i.dreq || cls_i.presp)
                                   : (cls_i.sync || cls_i.preq);
      SEL_W'(1): ev_hit = cls_i.sync || cls_i.dreq || peer_ev;
      SEL_W'(2): ev_hit = peer_ev;
      default:   ev_hit = own_ev || peer_ev;
    endcase
    want_o = cls_i.known && !cls_i.excluded &&
             (ev_hit || (!event_only_i && cls_i.general));
  end

endmodule

// File: rtl/ptp_rx_snap_filter.sv
module ptp_rx_snap_filter
  import ptp_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_en_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             frm_valid_i,
  input  logic [1:0]       frm_transport_i,
  input  logic [VER_W-1:0] frm_ver_i,
  input  logic [MSG_W-1:0] frm_msg_i,
  input  logic             frm_da_match_i,
  output logic             snap_take_o
);

  snap_cfg_t  cfg_q;
  msg_cls_t   cls;
  transport_e tr;
  logic       tr_pass;
  logic       want;
  logic       snap_d;
  logic       snap_q;

  assign tr = transport_e'(frm_transport_i);

  ptp_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .cfg_o  (cfg_q)
  );

  ptp_msg_classify u_cls (
    .v2_sel_i (cfg_q.v2_sel),
    .ver_i    (frm_ver_i),
    .msg_i    (frm_msg_i),
    .cls_o    (cls)
  );

  ptp_transport_gate u_gate (
    .ipv4_en_i   (cfg_q.ipv4_en),
    .ipv6_en_i   (cfg_q.ipv6_en),
    .eth_en_i    (cfg_q.eth_en),
    .da_filt_i   (cfg_q.da_filt),
    .transport_i (tr),
    .da_match_i  (frm_da_match_i),
    .pass_o      (tr_pass)
  );

  ptp_snap_policy u_pol (
    .sel_i        (cfg_q.snap_sel),
    .event_only_i (cfg_q.event_only),
    .master_i     (cfg_q.master),
    .cls_i        (cls),
    .want_o       (want)
  );

  always_comb begin
    snap_d = 1'b0;
    if (frm_valid_i && ts_en_i)
      snap_d = cfg_q.snap_all || (tr_pass && want);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= 1'b0;
    else        snap_q <= snap_d;
  end

  assign snap_take_o = snap_q;

  // R3
  pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_take_o |-> $past(frm_valid_i));

  // R2
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !ts_en_i) |=> !snap_take_o);

  // R4
  snap_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && ts_en_i && cfg_q.snap_all) |=> snap_take_o);

  // R9
  excluded_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !cfg_q.snap_all && cls.excluded) |=> !snap_take_o);

  // R12
  da_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !cfg_q.snap_all && cfg_q.da_filt && tr == TR_ETH &&
     !frm_da_match_i) |=> !snap_take_o);

  // R13
  unknown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !cfg_q.snap_all && !cls.known) |=> !snap_take_o);

  // R5
  non_ptp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !cfg_q.snap_all && tr == TR_NONE) |=> !snap_take_o);

endmodule

// File: tb/sim_ptp_rx_snap_filter.sv
`timescale 1ns/1ps
module sim_ptp_rx_snap_filter;

  logic       clk;
  logic       rst_n;
  logic       ts_en;
  logic       cfg_wr;
  logic [9:0] cfg_data;
  logic       fv;
  logic [1:0] ftr;
  logic [3:0] fver;
  logic [3:0] fmsg;
  logic       fda;
  logic       snap;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [1:0] T_NONE = 2'd0, T_ETH = 2'd1, T_U4 = 2'd2, T_U6 = 2'd3;

  ptp_rx_snap_filter u0 (
    .clk(clk), .rst_n(rst_n), .ts_en_i(ts_en), .cfg_wr_i(cfg_wr),
    .cfg_data_i(cfg_data), .frm_valid_i(fv), .frm_transport_i(ftr),
    .frm_ver_i(fver), .frm_msg_i(fmsg), .frm_da_match_i(fda),
    .snap_take_o(snap)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {sel[1:0], da_filt, master, event_only, v2, eth, v6, v4, all}
  function automatic logic [9:0] mk(input logic [1:0] sel, input logic da,
      input logic mst, input logic ev, input logic v2, input logic eth,
      input logic v6, input logic v4, input logic all);
    return {sel, da, mst, ev, v2, eth, v6, v4, all};
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wcfg(input logic [9:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // strobe one frame, check the pulse and its end
  task automatic send(input logic [1:0] tr, input logic [3:0] ver,
      input logic [3:0] msg, input logic da, input logic exp, input string tag);
    @(negedge clk);
    fv = 1'b1; ftr = tr; fver = ver; fmsg = msg; fda = da;
    @(negedge clk);
    fv = 1'b0;
    chk(snap, exp, tag);
    @(negedge clk);
    chk(snap, 1'b0, {tag, " R3 pulse end"});
  endtask

  task automatic t_reset;
    chk(snap, 1'b0, "R1 reset output");
    ts_en = 1'b1;
    send(T_U4, 4'd1, 4'd0, 1'b0, 1'b1, "R1 default ipv4 v1 sync");
    send(T_U6, 4'd1, 4'd0, 1'b0, 1'b0, "R1 default ipv6 off");
    send(T_ETH, 4'd1, 4'd0, 1'b1, 1'b0, "R1 default eth off");
  endtask

  task automatic t_global_off;
    wcfg(mk(2'd0, 0, 0, 0, 0, 1, 1, 1, 1));
    ts_en = 1'b0;
    send(T_U4, 4'd1, 4'd0, 1'b0, 1'b0, "R2 off snap_all sync");
    send(T_NONE, 4'd0, 4'd0, 1'b0, 1'b0, "R2 off non-ptp");
    ts_en = 1'b1;
  endtask

  task automatic t_snap_all;
    wcfg(mk(2'd0, 0, 0, 0, 0, 0, 0, 0, 1));
    send(T_NONE, 4'd0, 4'd5, 1'b0, 1'b1, "R4 non-ptp");
    send(T_U6, 4'd2, 4'd11, 1'b0, 1'b1, "R4 announce on disabled ipv6");
  endtask

  task automatic t_transport;
    wcfg(mk(2'd0, 0, 0, 1, 1, 1, 1, 0, 0));
    send(T_U6, 4'd2, 4'd0, 1'b0, 1'b1, "R5 ipv6 enabled");
    send(T_ETH, 4'd2, 4'd0, 1'b0, 1'b1, "R5 eth enabled");
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b0, "R5 ipv4 disabled");
    send(T_NONE, 4'd2, 4'd0, 1'b0, 1'b0, "R5 non-ptp");
  endtask

  task automatic t_version;
    wcfg(mk(2'd0, 0, 0, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd1, 4'd0, 1'b0, 1'b0, "R6 v1 frame under v2");
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b1, "R6 v2 sync");
    wcfg(mk(2'd0, 0, 0, 0, 0, 0, 0, 1, 0));
    send(T_U4, 4'd1, 4'd2, 1'b0, 1'b1, "R6 v1 follow_up");
    send(T_U4, 4'd1, 4'd4, 1'b0, 1'b0, "R6 v1 management");
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b0, "R6 v2 frame under v1");
  endtask

  task automatic t_event_slave;
    wcfg(mk(2'd0, 0, 0, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b1, "R7 sync");
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b0, "R7 delay_req");
    send(T_U4, 4'd2, 4'd2, 1'b0, 1'b1, "R7 pdelay_req");
    send(T_U4, 4'd2, 4'd3, 1'b0, 1'b0, "R7 pdelay_resp");
    send(T_U4, 4'd2, 4'd8, 1'b0, 1'b0, "R7 follow_up");
  endtask

  task automatic t_event_master;
    wcfg(mk(2'd0, 0, 1, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b1, "R8 delay_req");
    send(T_U4, 4'd2, 4'd3, 1'b0, 1'b1, "R8 pdelay_resp");
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b0, "R8 sync");
    send(T_U4, 4'd2, 4'd2, 1'b0, 1'b0, "R8 pdelay_req");
  endtask

  task automatic t_general;
    wcfg(mk(2'd0, 0, 0, 0, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd8, 1'b0, 1'b1, "R9 follow_up");
    send(T_U4, 4'd2, 4'd9, 1'b0, 1'b1, "R9 delay_resp");
    send(T_U4, 4'd2, 4'd10, 1'b0, 1'b1, "R9 pdelay_resp_fu");
    send(T_U4, 4'd2, 4'd11, 1'b0, 1'b0, "R9 announce");
    send(T_U4, 4'd2, 4'd12, 1'b0, 1'b0, "R9 signaling");
    send(T_U4, 4'd2, 4'd13, 1'b0, 1'b0, "R9 management");
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b0, "R9 delay_req slave");
  endtask

  task automatic t_sel;
    wcfg(mk(2'd1, 0, 1, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b1, "R10 sync");
    send(T_U4, 4'd2, 4'd2, 1'b0, 1'b1, "R10 pdelay_req");
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b1, "R10 delay_req");
    wcfg(mk(2'd2, 0, 0, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b0, "R11 sel2 sync");
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b0, "R11 sel2 delay_req");
    send(T_U4, 4'd2, 4'd2, 1'b0, 1'b1, "R11 sel2 pdelay_req");
    send(T_U4, 4'd2, 4'd3, 1'b0, 1'b1, "R11 sel2 pdelay_resp");
    wcfg(mk(2'd3, 0, 0, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b1, "R11 sel3 slave sync");
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b0, "R11 sel3 slave delay_req");
    send(T_U4, 4'd2, 4'd3, 1'b0, 1'b1, "R11 sel3 slave pdelay_resp");
    wcfg(mk(2'd3, 0, 1, 1, 1, 0, 0, 1, 0));
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b0, "R11 sel3 master sync");
    send(T_U4, 4'd2, 4'd1, 1'b0, 1'b1, "R11 sel3 master delay_req");
  endtask

  task automatic t_da_filter;
    wcfg(mk(2'd0, 1, 0, 1, 1, 1, 0, 1, 0));
    send(T_ETH, 4'd2, 4'd0, 1'b0, 1'b0, "R12 eth no match");
    send(T_ETH, 4'd2, 4'd0, 1'b1, 1'b1, "R12 eth match");
    send(T_U4, 4'd2, 4'd0, 1'b0, 1'b1, "R12 udp unaffected");
  endtask

  task automatic t_unknown;
    wcfg(mk(2'd1, 0, 0, 0, 1, 0, 0, 1, 0));
    for (int c = 4; c < 16; c++) begin
      if (c == 8) c = 14;
      send(T_U4, 4'd2, 4'(c), 1'b0, 1'b0, "R13 undefined code");
    end
  endtask

  task automatic t_back_to_back;
    wcfg(mk(2'd0, 0, 0, 1, 1, 0, 0, 1, 0));
    @(negedge clk);
    fv = 1'b1; ftr = T_U4; fver = 4'd2; fmsg = 4'd0; fda = 1'b0;
    @(negedge clk);
    fmsg = 4'd2;
    chk(snap, 1'b1, "R3 first of pair");
    @(negedge clk);
    fv = 1'b0;
    chk(snap, 1'b1, "R3 second of pair");
    @(negedge clk);
    chk(snap, 1'b0, "R3 after pair");
  endtask

  initial begin
    rst_n = 1'b0; ts_en = 1'b0; cfg_wr = 1'b0; cfg_data = '0;
    fv = 1'b0; ftr = '0; fver = '0; fmsg = '0; fda = 1'b0;
    repeat (4) @(negedge clk);
    chk(snap, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global_off();
    t_snap_all();
    t_transport();
    t_version();
    t_event_slave();
    t_event_master();
    t_general();
    t_sel();
    t_da_filter();
    t_unknown();
    t_back_to_back();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule